// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Front End

This block sits in front of a small on-chip word memory and accepts one command on every clock, so reads and writes can follow each other with no dead cycle between them. A command is a load of a new address together with the read/write select, the per-lane write enables and three chip selects. It can also be a continuation that steps through a four-word burst started by the last load. Write data does not come with its address: it is sampled two enabled clock edges later, so the data bus carries a fixed-latency stream in both directions.

The write data lands in a late-write register. Its contents move into the array only when the next write arrives. A read that hits that pending address is served from the register, lane by lane, so a read always returns the newest data. Read data is registered and appears two enabled edges after its address. It is driven only for read results and only while the output enable is low. An active-low clock enable freezes the whole pipeline for as long as it is high.

Top module: `zt_sram`

## Requirements
- R1: After reset the block is deselected, `rdata_oe` is 0 and `rdata` is 0.
- R2: At an enabled edge with `ld_n` low, the block is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other combination is a deselect: no array or register contents change, and the result slot two edges later is not driven.
- R3: A selected load with `wr_n`=1 is a read. The word at its address appears on `rdata` with `rdata_oe`=1 after the second enabled edge following the load edge, and it stays until the next enabled edge.
- R4: A selected load with `wr_n`=0 is a write. `wdata` is sampled at the second enabled edge after the address edge. The lane enables are sampled with the address, and lane i (bits 9i+8..9i) is written only when `lane_we_n[i]` is 0. With all four enables at 1 the write is an abort and changes nothing.
- R5: Reads and writes can alternate on consecutive edges. A read issued after a write to the same address returns the newest data, merging partly written lanes with the older contents.
- R6: With `ld_n` high, `wr_n` and the chip selects are ignored and the cycle repeats the type of the last load. The address steps within its aligned group of four: it keeps the upper bits, and the low two bits follow base+1, base+2, base+3 modulo 4 (linear order, the default). Lane enables are sampled again on each step.
- R7: A continuation after a deselect, or after reset, stays deselected.
- R8: An edge with `cke_n` high is ignored. No state changes, no write data is sampled, and `rdata`/`rdata_oe` keep their values: driven if a read result is showing, undriven if a write slot is showing.
- R9: `rdata_oe` is 1 only for a read result while `oe_n` is 0, and `oe_n` acts without a clock. Write and deselect slots are never driven, and `rdata` reads 0 whenever `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| ld_n | input | 1 | Low: load new address and command; high: continue burst |
| wr_n | input | 1 | Command type at a load: 0 write, 1 read |
| sel_a_n | input | 1 | Active-low chip select, sampled at loads |
| sel_b_n | input | 1 | Second active-low chip select, sampled at loads |
| sel_c | input | 1 | Active-high chip select, sampled at loads |
| lane_we_n | input | LANES (4) | Active-low write enable per 9-bit lane |
| addr | input | log2(DEPTH) (6) | Word address |
| wdata | input | LANES*LANE_W (36) | Write data, two enabled edges after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W (36) | Registered read data, 0 when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The assertions take for granted that `cke_n`, `ld_n`, `wr_n`, the selects and the lane enables are at clean 0/1 levels at every rising edge after reset. They also assume `oe_n` changes only away from clock edges. The burst-type check further assumes that a continuation always follows a selected or deselected load, never a partly defined state. The stimulus drives every input at the falling edge from one cycle task, keeps `oe_n` low except in one dedicated check between edges, and reads back only addresses whose lanes it has written.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   // Kind of operation occupying a pipeline slot.
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } zt_cyc_e;

endpackage

// File: rtl/zt_sram_cmd.sv
module zt_sram_cmd
   import zt_sram_pkg::*;
#(
   parameter int AW           = 6,
   parameter int LANES        = 4,
   parameter int BURST_LEN    = 4,
   parameter bit LINEAR_BURST = 1'b1,
   localparam int BW          = $clog2(BURST_LEN)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_en,
   input  logic             ld_n,
   input  logic             wr_n,
   input  logic             sel_a_n,
   input  logic             sel_b_n,
   input  logic             sel_c,
   input  logic [LANES-1:0] lane_we_n,
   input  logic [AW-1:0]    addr,
   output zt_cyc_e          cyc_q,
   output logic [AW-1:0]    addr_q,
   output logic [LANES-1:0] mask_q
);

   zt_cyc_e       bst_kind;
   zt_cyc_e       ld_kind;
   logic [AW-1:0] bst_base;
   logic [BW-1:0] bst_cnt;
   logic [BW-1:0] nxt_cnt;
   logic [BW-1:0] step_lo;
   logic          chip_on;

   assign chip_on = ~sel_a_n & ~sel_b_n & sel_c;
   assign ld_kind = !chip_on ? CYC_IDLE : (wr_n ? CYC_READ : CYC_WRITE);
   assign nxt_cnt = bst_cnt + 1'b1;

   // Burst order variant chosen at elaboration.
   generate
      if (LINEAR_BURST) begin : g_linear
         assign step_lo = bst_base[BW-1:0] + nxt_cnt;
      end else begin : g_interleave
         assign step_lo = bst_base[BW-1:0] ^ nxt_cnt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q    <= CYC_IDLE;
         bst_kind <= CYC_IDLE;
         bst_base <= '0;
         bst_cnt  <= '0;
         addr_q   <= '0;
         mask_q   <= '0;
      end else if (adv_en) begin
         mask_q <= ~lane_we_n;
         if (!ld_n) begin
            bst_cnt  <= '0;
            bst_kind <= ld_kind;
            cyc_q    <= ld_kind;
            if (chip_on) begin
               bst_base <= addr;
               addr_q   <= addr;
            end
         end else begin
            bst_cnt <= nxt_cnt;
            addr_q  <= {bst_base[AW-1:BW], step_lo};
            cyc_q   <= bst_kind;
         end
      end
   end

   // R2: a load without the full select pattern yields an idle slot
   a_r2_desel_load: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !ld_n && (sel_a_n || sel_b_n || !sel_c)) |=> (cyc_q == CYC_IDLE));

   // R7: continuing from a deselect stays deselected
   a_r7_cont_desel: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && ld_n && (cyc_q == CYC_IDLE)) |=> (cyc_q == CYC_IDLE));

   // R6: a continuation keeps the command type of its burst
   a_r6_cont_type: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && ld_n && (cyc_q != CYC_IDLE)) |=> (cyc_q == $past(cyc_q)));

   // R6: a continuation stays inside its aligned burst group
   a_r6_cont_group: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && ld_n && (cyc_q != CYC_IDLE)) |=> (addr_q[AW-1:BW] == $past(addr_q[AW-1:BW])));

   // R8: an ignored edge leaves the command stage untouched
   a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> ($stable(cyc_q) && $stable(addr_q) && $stable(mask_q)));

endmodule

// File: rtl/zt_sram_lwbuf.sv
module zt_sram_lwbuf #(
   parameter int LANES    = 4,
   parameter int LANE_W   = 9,
   parameter int DEPTH    = 64,
   localparam int AW      = $clog2(DEPTH),
   localparam int DW      = LANES * LANE_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_en,
   input  logic             cap_en,
   input  logic [AW-1:0]    cap_addr,
   input  logic [LANES-1:0] cap_mask,
   input  logic [DW-1:0]    cap_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_word
);

   logic             lw_vld;
   logic [AW-1:0]    lw_addr;
   logic [LANES-1:0] lw_mask;
   logic [DW-1:0]    lw_data;
   logic             lw_hit;
   logic             retire;

   // Pending write moves to the array when the next write is captured.
   assign retire = adv_en && cap_en && lw_vld;
   assign lw_hit = lw_vld && (lw_addr == rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lw_vld  <= 1'b0;
         lw_addr <= '0;
         lw_mask <= '0;
         lw_data <= '0;
      end else if (adv_en && cap_en) begin
         lw_vld  <= 1'b1;
         lw_addr <= cap_addr;
         lw_mask <= cap_mask;
         lw_data <= cap_data;
      end
   end

   // One storage column per lane, with lane-wise forwarding.
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (retire && lw_mask[g])
               mem[lw_addr] <= lw_data[g*LANE_W +: LANE_W];
         end

         assign rd_word[g*LANE_W +: LANE_W] = (lw_hit && lw_mask[g])
                                            ? lw_data[g*LANE_W +: LANE_W]
                                            : mem[rd_addr];
      end
   endgenerate

   // R8: an ignored edge neither captures nor retires write data
   a_r8_lw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> ($stable(lw_vld) && $stable(lw_addr) && $stable(lw_data) && $stable(lw_mask)));

   // R5: once captured, the pending write stays visible until replaced
   a_r5_lw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lw_vld |=> lw_vld);

endmodule

// File: rtl/zt_sram_rdout.sv
module zt_sram_rdout #(
   parameter int DW = 36
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_en,
   input  logic          rd_take,
   input  logic [DW-1:0] rd_word,
   input  logic          oe_n,
   output logic [DW-1:0] rdata,
   output logic          rdata_oe
);

   logic [DW-1:0] rq;
   logic          rv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rq <= '0;
         rv <= 1'b0;
      end else if (adv_en) begin
         rv <= rd_take;
         if (rd_take)
            rq <= rd_word;
      end
   end

   assign rdata_oe = rv & ~oe_n;
   assign rdata    = rdata_oe ? rq : '0;

   // R8: the output register holds across an ignored edge
   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> ($stable(rq) && $stable(rv)));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int LANES        = 4,
   parameter int LANE_W       = 9,
   parameter int DEPTH        = 64,
   parameter int BURST_LEN    = 4,
   parameter bit LINEAR_BURST = 1'b1,
   localparam int AW          = $clog2(DEPTH),
   localparam int DW          = LANES * LANE_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke_n,
   input  logic             ld_n,
   input  logic             wr_n,
   input  logic             sel_a_n,
   input  logic             sel_b_n,
   input  logic             sel_c,
   input  logic [LANES-1:0] lane_we_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             oe_n,
   output logic [DW-1:0]    rdata,
   output logic             rdata_oe
);

   // Elaboration-time parameter checks.
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("zt_sram: DEPTH must be a power of two");
      end
      if ((BURST_LEN & (BURST_LEN - 1)) != 0 || BURST_LEN < 2) begin : g_bad_burst
         $error("zt_sram: BURST_LEN must be a power of two of at least 2");
      end
      if (BURST_LEN >= DEPTH) begin : g_burst_span
         $error("zt_sram: BURST_LEN must be below DEPTH");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("zt_sram: lane shape must be non-empty");
      end
   endgenerate

   logic             adv_en;
   zt_cyc_e          s1_cyc;
   logic [AW-1:0]    s1_addr;
   logic [LANES-1:0] s1_mask;
   zt_cyc_e          s2_cyc;
   logic [AW-1:0]    s2_addr;
   logic [LANES-1:0] s2_mask;
   logic [DW-1:0]    rd_word;
   logic             s2_wr;
   logic             s2_rd;

   assign adv_en = ~cke_n;
   assign s2_wr  = (s2_cyc == CYC_WRITE);
   assign s2_rd  = (s2_cyc == CYC_READ);

   zt_sram_cmd #(
      .AW           (AW),
      .LANES        (LANES),
      .BURST_LEN    (BURST_LEN),
      .LINEAR_BURST (LINEAR_BURST)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_en    (adv_en),
      .ld_n      (ld_n),
      .wr_n      (wr_n),
      .sel_a_n   (sel_a_n),
      .sel_b_n   (sel_b_n),
      .sel_c     (sel_c),
      .lane_we_n (lane_we_n),
      .addr      (addr),
      .cyc_q     (s1_cyc),
      .addr_q    (s1_addr),
      .mask_q    (s1_mask)
   );

   // Second command stage: lines the command up with its write data.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_cyc  <= CYC_IDLE;
         s2_addr <= '0;
         s2_mask <= '0;
      end else if (adv_en) begin
         s2_cyc  <= s1_cyc;
         s2_addr <= s1_addr;
         s2_mask <= s1_mask;
      end
   end

   zt_sram_lwbuf #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .DEPTH  (DEPTH)
   ) u_lwbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_en   (adv_en),
      .cap_en   (s2_wr),
      .cap_addr (s2_addr),
      .cap_mask (s2_mask),
      .cap_data (wdata),
      .rd_addr  (s2_addr),
      .rd_word  (rd_word)
   );

   zt_sram_rdout #(
      .DW (DW)
   ) u_rdout (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_en   (adv_en),
      .rd_take  (s2_rd),
      .rd_word  (rd_word),
      .oe_n     (oe_n),
      .rdata    (rdata),
      .rdata_oe (rdata_oe)
   );

   // R9: a write slot reaching the output leaves the bus undriven
   a_r9_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && s2_wr) |=> !rdata_oe);

   // R2: a deselected slot reaching the output leaves the bus undriven
   a_r2_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && (s2_cyc == CYC_IDLE)) |=> !rdata_oe);

   // R8: an ignored edge holds the middle stage
   a_r8_s2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(s2_cyc) && $stable(s2_addr)));

   // R1: reset state is deselected and undriven
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (!rdata_oe && (s2_cyc == CYC_IDLE)));

endmodule

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;

   localparam int LANES = 4;
   localparam int LW    = 9;
   localparam int DW    = 36;
   localparam int AW    = 6;
   localparam logic [DW-1:0] JUNK = 36'h9_DEAD_BEEF;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cke_n, ld_n, wr_n, sel_a_n, sel_b_n, sel_c, oe_n;
   logic [LANES-1:0] lane_we_n;
   logic [AW-1:0]   addr;
   logic [DW-1:0]   wdata;
   logic [DW-1:0]   rdata;
   logic            rdata_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   zt_sram uut (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .wr_n(wr_n),
      .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
      .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   // Reference model state
   logic [DW-1:0] ref_mem [64];
   int            p0_kind = 0, p1_kind = 0;        // 0 none, 1 read, 2 write
   logic [DW-1:0] p0_exp, p1_exp, p0_wd, p1_wd;
   string         p0_tag = "R1", p1_tag = "R1";
   int            bk = 0;                          // burst kind
   logic [AW-1:0] bbase = '0;
   logic [1:0]    bcnt = '0;
   logic          last_oe = 1'b0;
   logic [DW-1:0] last_rd = '0;

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, step past the rising edge,
   // sample at the next falling edge.
   task automatic tick(input logic stall, input logic ld, input logic wr,
                       input logic sa, input logic sb, input logic sc,
                       input logic [3:0] be, input logic [AW-1:0] ad,
                       input logic [DW-1:0] d, input string tag);
      int            kind;
      logic [AW-1:0] a;
      logic [DW-1:0] m;
      cke_n = stall; ld_n = ld; wr_n = wr;
      sel_a_n = sa; sel_b_n = sb; sel_c = sc;
      lane_we_n = be; addr = ad;
      if (stall) begin
         wdata = JUNK;
         @(posedge clk); @(negedge clk);
         check({tag, " R8 hold drive"}, {35'd0, rdata_oe}, {35'd0, last_oe});
         check({tag, " R8 hold data"}, rdata, last_rd);
         return;
      end
      wdata = (p1_kind == 2) ? p1_wd : JUNK;
      kind = 0; a = ad; m = '0;
      if (!ld) begin
         bcnt = '0;
         if (!sa && !sb && sc) begin
            kind = wr ? 1 : 2;
            bbase = ad;
         end
         bk = kind;
      end else begin
         kind = bk;
         bcnt = bcnt + 2'd1;
         a = {bbase[AW-1:2], bbase[1:0] + bcnt};
      end
      if (kind == 2) begin
         m = ref_mem[a];
         for (int i = 0; i < LANES; i++)
            if (!be[i]) m[i*LW +: LW] = d[i*LW +: LW];
         ref_mem[a] = m;
      end else if (kind == 1) begin
         m = ref_mem[a];
      end
      @(posedge clk); @(negedge clk);
      if (p1_kind == 1) begin
         check({p1_tag, " R3 drive"}, {35'd0, rdata_oe}, 36'd1);
         check({p1_tag, " R3 data"}, rdata, p1_exp);
      end else begin
         check({p1_tag, " R9 undriven"}, {35'd0, rdata_oe}, 36'd0);
         check({p1_tag, " R9 zero"}, rdata, '0);
      end
      p1_kind = p0_kind; p1_exp = p0_exp; p1_wd = p0_wd; p1_tag = p0_tag;
      p0_kind = kind;    p0_exp = m;      p0_wd = d;     p0_tag = tag;
      last_oe = rdata_oe; last_rd = rdata;
   endtask

   task automatic wr_op(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d, input string tag);
      tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, be, a, d, tag);
   endtask
   task automatic rd_op(input logic [AW-1:0] a, input string tag);
      tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a, JUNK, tag);
   endtask
   // Continuation: selects driven to a deselect pattern to show they are ignored.
   task automatic cont(input logic w, input logic [3:0] be, input logic [DW-1:0] d, input string tag);
      tick(1'b0, 1'b1, w, 1'b1, 1'b1, 1'b0, be, 6'h3F, d, tag);
   endtask
   task automatic nop(input string tag);
      tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, '0, JUNK, tag);
   endtask
   task automatic stall_op(input string tag);
      tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, '0, JUNK, tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cke_n = 1'b0; ld_n = 1'b1; wr_n = 1'b1;
      sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0; oe_n = 1'b0;
      lane_we_n = 4'hF; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset drive", {35'd0, rdata_oe}, 36'd0);
      check("R1 reset data", rdata, '0);
      rst_n = 1'b1;
      cont(1'b0, 4'h0, JUNK, "R7 continue after reset");
      cont(1'b1, 4'h0, JUNK, "R7 continue after reset");
      cont(1'b0, 4'h0, JUNK, "R1/R7 idle");
      nop("R1 drain");
   endtask

   task automatic t_basic();
      wr_op(6'd0, 4'h0, 36'h1_2345_6789, "R4 full write");
      wr_op(6'd1, 4'h0, 36'hA_BCDE_F012, "R4 full write");
      rd_op(6'd0, "R3 read back");
      rd_op(6'd1, "R3 read back");
      nop("R3 drain"); nop("R3 drain");
      rd_op(6'd0, "R4 read from array");
      nop("R4 drain"); nop("R4 drain");
   endtask

   task automatic t_alternate();
      wr_op(6'd5, 4'h0, 36'h5_5555_0001, "R5 alt");
      rd_op(6'd5, "R5 alt read newest");
      wr_op(6'd5, 4'h0, 36'h5_5555_0002, "R5 alt");
      rd_op(6'd5, "R5 alt read newest");
      wr_op(6'd9, 4'h0, 36'h9_9999_0003, "R5 alt");
      rd_op(6'd5, "R5 alt read after retire");
      rd_op(6'd9, "R5 alt read pending");
      nop("R5 drain"); nop("R5 drain");
   endtask

   task automatic t_lanes();
      wr_op(6'd7, 4'h0, 36'h7_7777_7777, "R4 lanes base");
      wr_op(6'd7, 4'b1010, 36'hC_3333_CCCC, "R4 lanes 0 and 2");
      rd_op(6'd7, "R5 lane merge pending");
      wr_op(6'd7, 4'hF, 36'h0_0000_0000, "R4 abort");
      rd_op(6'd7, "R4 abort no change");
      wr_op(6'd8, 4'b0111, 36'hF_0000_0000, "R4 lane 3 only");
      wr_op(6'd3, 4'h0, 36'h3_0303_0303, "R4 retire");
      rd_op(6'd7, "R4 lanes from array");
      nop("R4 drain"); nop("R4 drain");
   endtask

   task automatic t_deselect();
      tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd5, JUNK, "R2 sel_a high");
      tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd5, JUNK, "R2 sel_b high");
      tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 6'd5, JUNK, "R2 sel_c low");
      tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 6'd5, JUNK, "R2 deselected write");
      cont(1'b0, 4'h0, JUNK, "R7 continue deselect");
      cont(1'b1, 4'h0, JUNK, "R7 continue deselect");
      rd_op(6'd5, "R2 contents kept");
      nop("R2 drain"); nop("R2 drain");
   endtask

   task automatic t_burst();
      wr_op(6'd6, 4'h0, 36'hB_0000_0000, "R6 burst write");
      cont(1'b1, 4'h0, 36'hB_0000_0001, "R6 burst step wr_n ignored");
      cont(1'b1, 4'h0, 36'hB_0000_0002, "R6 burst step");
      cont(1'b0, 4'h0, 36'hB_0000_0003, "R6 burst step");
      rd_op(6'd6, "R6 burst read");
      cont(1'b0, 4'h0, JUNK, "R6 burst read step 7");
      cont(1'b0, 4'h0, JUNK, "R6 burst read step 4");
      cont(1'b1, 4'h0, JUNK, "R6 burst read step 5");
      nop("R6 drain"); nop("R6 drain");
   endtask

   task automatic t_stall();
      wr_op(6'd12, 4'h0, 36'hD_1212_1212, "R8 write");
      rd_op(6'd12, "R8 read after stalled write");
      stall_op("R8 stall on write");
      stall_op("R8 stall on write");
      rd_op(6'd12, "R8 second read");
      nop("R8 nop");
      stall_op("R8 stall on read");
      stall_op("R8 stall on read");
      nop("R8 drain"); nop("R8 drain");
   endtask

   task automatic t_oe();
      wr_op(6'd20, 4'h0, 36'h2_0202_0202, "R9 write");
      rd_op(6'd20, "R9 read");
      nop("R9 nop");
      nop("R9 nop");
      oe_n = 1'b1; #1;
      check("R9 oe_n high drive", {35'd0, rdata_oe}, 36'd0);
      check("R9 oe_n high data", rdata, '0);
      oe_n = 1'b0; #1;
      check("R9 oe_n low drive", {35'd0, rdata_oe}, 36'd1);
      check("R9 oe_n low data", rdata, 36'h2_0202_0202);
      nop("R9 drain");
   endtask

   initial begin
      for (int i = 0; i < 64; i++) ref_mem[i] = '0;
      @(negedge clk);
      t_reset();
      t_basic();
      t_alternate();
      t_lanes();
      t_deselect();
      t_burst();
      t_stall();
      t_oe();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule